// File: doc/BRIEF.md
# Even-Depth Dual-Clock FIFO

This block passes data words from one clock domain to an unrelated one through a small register-array store. The storage depth is a parameter that may be any even number of two or more, including values that are not powers of two, such as 6. The writing side offers a word with a write enable and is told through `full` when no slot is free. The reading side pulls words with a read enable. It sees `empty` when nothing is waiting, and each accepted word arrives on `rd_data` one read clock later.

Each side keeps a position counter that runs over 2×DEPTH positions. The counter is also held in a registered Gray form, and only that Gray form is passed to the other side, through two flip-flops clocked by the receiving clock. The Gray sequence is the central run of 2×DEPTH codewords taken from the smallest reflected Gray code that holds them. Because that run sits symmetrically in the code, the step from the last position back to the first also flips exactly one bit. The receiving side turns the synchronized code back into a position. Each bit of the result is the XOR of all code bits at and above it, and the run's starting offset is then subtracted. An odd or too-small depth stops elaboration. Each side has its own synchronous active-high reset.

Top module: `even_fifo`

## Requirements
- R1: While and right after reset, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: With no reads, `full` rises on the `wr_clk` edge that accepts the DEPTH-th write and stays 0 before that. DEPTH must be even and at least 2, and the default of 6 is supported. Any other value fails elaboration.
- R3: A write requested while `full` is 1 is ignored. The write pointer and the stored words are left unchanged.
- R4: A read requested while `empty` is 1 is ignored. The read pointer and `rd_data` are left unchanged.
- R5: `rd_data` is loaded on the `rd_clk` edge that accepts a read, and it delivers words in the order they were written.
- R6: Each registered Gray pointer changes at most one bit per edge of its own clock, including the wrap from position 2×DEPTH−1 back to 0.
- R7: After a write is accepted into an empty FIFO, `empty` is 0 by the third `rd_clk` rising edge after the accepting `wr_clk` edge.
- R8: After a read is accepted from a full FIFO, `full` is 0 by the third `wr_clk` rising edge after the accepting `rd_clk` edge.
- R9: With both sides working at once on unrelated clocks, over several pointer wraps, every accepted word is read exactly once and in order.
- R10: `rd_data` holds its value on every `rd_clk` edge that accepts no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_en | input | 1 | Request to store `wr_data` |
| wr_data | input | DW | Word to store |
| full | output | 1 | No free slot; writes are ignored |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_en | input | 1 | Request to take the oldest word |
| rd_data | output | DW | Word taken by the last accepted read |
| empty | output | 1 | Nothing stored; reads are ignored |

## Verification
A pointer that skips or repeats a position shows up on `rd_data` as a missing, doubled or stale word at the next read that reaches that slot. The same fault also makes `full` or `empty` disagree with the true fill level within three edges of the other clock. A Gray code error, such as a wrong offset, a non-cyclic wrap or a bad decode, gives the wrong distance between the pointers. This appears as `full` rising before or after the DEPTH-th write, or as `empty` staying high after a write. The directed tests cover that distance at the boundary of DEPTH. The streaming test runs several wraps so that a fault at the wrap point reaches the ports within one lap of 2×DEPTH words.

// File: rtl/efifo_pkg.sv
`timescale 1ns/1ps
package efifo_pkg;

  // Bits in a pointer that counts 2*depth positions.
  function automatic int ptr_bits(input int depth);
    return $clog2(2 * depth);
  endfunction

  // Bits needed to address depth slots (at least one).
  function automatic int addr_bits(input int depth);
    return (depth > 2) ? $clog2(depth) : 1;
  endfunction

  // Index of the first reflected-Gray codeword used, so that the run of
  // 2*depth codewords sits symmetrically in the code and wraps cleanly.
  function automatic int code_offset(input int depth);
    return ((1 << ptr_bits(depth)) - 2 * depth) / 2;
  endfunction

  function automatic int gray_of(input int value);
    return value ^ (value >> 1);
  endfunction

endpackage

// File: rtl/efifo_ptr.sv
`timescale 1ns/1ps
// Position counter over 2*DEPTH steps with a registered Gray copy and
// a separate slot address that wraps at DEPTH.
module efifo_ptr #(
  parameter int DEPTH = 6,
  parameter int PW    = efifo_pkg::ptr_bits(DEPTH),
  parameter int AW    = efifo_pkg::addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [PW-1:0] bin_nx,
  output logic [PW-1:0] gray,
  output logic [AW-1:0] addr
);
  localparam int            OFFS   = efifo_pkg::code_offset(DEPTH);
  localparam logic [PW-1:0] LAST   = PW'(2 * DEPTH - 1);
  localparam logic [PW-1:0] OFFS_V = PW'(OFFS);
  localparam logic [PW-1:0] GRAY0  = PW'(efifo_pkg::gray_of(OFFS));
  localparam logic [AW-1:0] ALAST  = AW'(DEPTH - 1);

  logic [PW-1:0] bin_q;
  logic [PW-1:0] code_nx;
  logic [PW-1:0] gray_nx;

  always_comb begin
    bin_nx = bin_q;
    if (inc) bin_nx = (bin_q == LAST) ? '0 : bin_q + 1'b1;
    code_nx = bin_nx + OFFS_V;
    gray_nx = code_nx ^ (code_nx >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q <= '0;
      gray  <= GRAY0;
      addr  <= '0;
    end else begin
      bin_q <= bin_nx;
      gray  <= gray_nx;
      if (inc) addr <= (addr == ALAST) ? '0 : addr + 1'b1;
    end
  end
endmodule

// File: rtl/efifo_sync.sv
`timescale 1ns/1ps
// Two flip-flops in series in the receiving clock domain.
module efifo_sync #(
  parameter int           W    = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/efifo_gray_dec.sv
`timescale 1ns/1ps
// Turns a codeword of the offset Gray run back into a position.
module efifo_gray_dec #(
  parameter int PW   = 4,
  parameter int OFFS = 2
) (
  input  logic [PW-1:0] gray,
  output logic [PW-1:0] bin
);
  logic [PW-1:0] code_idx;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign code_idx[i] = ^(gray >> i);
  end

  assign bin = code_idx - PW'(OFFS);
endmodule

// File: rtl/efifo_mem.sv
`timescale 1ns/1ps
// Storage: write port on wr_clk, registered read port on rd_clk.
module efifo_mem #(
  parameter int DEPTH = 6,
  parameter int AW    = 3,
  parameter int DW    = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/even_fifo.sv
`timescale 1ns/1ps
module even_fifo #(
  parameter int DEPTH = 6,
  parameter int DW    = 8
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int            PW    = efifo_pkg::ptr_bits(DEPTH);
  localparam int            AW    = efifo_pkg::addr_bits(DEPTH);
  localparam int            OFFS  = efifo_pkg::code_offset(DEPTH);
  localparam logic [PW-1:0] GRAY0 = PW'(efifo_pkg::gray_of(OFFS));
  localparam logic [PW:0]   LAP   = (PW+1)'(2 * DEPTH);
  localparam logic [PW:0]   HALF  = (PW+1)'(DEPTH);

  if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
    $error("even_fifo: DEPTH must be even and at least 2");
  end

  // ---------------- write domain ----------------
  logic          full_q, full_nx, wr_ok;
  logic [PW-1:0] wbin_nx, wgray, rgray_w, rbin_w;
  logic [AW-1:0] waddr;
  logic [PW:0]   span;

  assign wr_ok = wr_en & ~full_q;

  efifo_ptr #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_wptr (
    .clk(wr_clk), .rst(wr_rst), .inc(wr_ok),
    .bin_nx(wbin_nx), .gray(wgray), .addr(waddr)
  );

  efifo_sync #(.W(PW), .INIT(GRAY0)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_w)
  );

  efifo_gray_dec #(.PW(PW), .OFFS(OFFS)) u_rdec (
    .gray(rgray_w), .bin(rbin_w)
  );

  always_comb begin
    span = {1'b0, wbin_nx} - {1'b0, rbin_w};
    if (wbin_nx < rbin_w) span = span + LAP;
    full_nx = (span == HALF);
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) full_q <= 1'b0;
    else        full_q <= full_nx;
  end

  // ---------------- read domain ----------------
  logic          empty_q, empty_nx, rd_ok;
  logic [PW-1:0] rbin_nx, rgray, wgray_r, wbin_r;
  logic [AW-1:0] raddr;

  assign rd_ok = rd_en & ~empty_q;

  efifo_ptr #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_rptr (
    .clk(rd_clk), .rst(rd_rst), .inc(rd_ok),
    .bin_nx(rbin_nx), .gray(rgray), .addr(raddr)
  );

  efifo_sync #(.W(PW), .INIT(GRAY0)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_r)
  );

  efifo_gray_dec #(.PW(PW), .OFFS(OFFS)) u_wdec (
    .gray(wgray_r), .bin(wbin_r)
  );

  assign empty_nx = (rbin_nx == wbin_r);

  always_ff @(posedge rd_clk) begin
    if (rd_rst) empty_q <= 1'b1;
    else        empty_q <= empty_nx;
  end

  // ---------------- storage ----------------
  efifo_mem #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_mem (
    .wr_clk(wr_clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .re(rd_ok), .raddr(raddr),
    .rdata(rd_data)
  );

  assign full  = full_q;
  assign empty = empty_q;
endmodule

// File: rtl/efifo_checks.sv
`timescale 1ns/1ps
module efifo_checks #(
  parameter int PW = 4,
  parameter int DW = 8
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_en,
  input logic          full,
  input logic [PW-1:0] wgray,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_en,
  input logic          empty,
  input logic [PW-1:0] rgray,
  input logic [DW-1:0] rd_data
);
  assert_wgray_one_step_R6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_one_step_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (full && wr_en) |=> $stable(wgray));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (empty && rd_en) |=> ($stable(rgray) && $stable(rd_data)));

  assert_data_hold_R10: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind even_fifo efifo_checks #(.PW(PW), .DW(DW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .full(full), .wgray(wgray),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .empty(empty), .rgray(rgray),
  .rd_data(rd_data)
);

// File: tb/test_even_fifo.sv
`timescale 1ns/1ps
module test_even_fifo;
  localparam int DEPTH = 6;
  localparam int DW    = 8;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          full, empty;
  logic [DW-1:0] rd_data;

  always #5   wr_clk = ~wr_clk;   // 100 MHz
  always #6.5 rd_clk = ~rd_clk;   // unrelated read clock

  even_fifo #(.DEPTH(DEPTH), .DW(DW)) i_even_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] model[$];

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    if (!full) model.push_back(d);
    @(posedge wr_clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic pop_expect(input string req);
    logic [DW-1:0] exp;
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(posedge rd_clk);
    #1 rd_en = 1'b0;
    exp = model.pop_front();
    check_eq(req, "rd_data", int'(rd_data), int'(exp));
  endtask

  task automatic settle();
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    #1;
  endtask

  task automatic t_reset();  // R1
    #1;
    check_eq("R1", "empty at reset", int'(empty), 1);
    check_eq("R1", "full at reset", int'(full), 0);
    check_eq("R1", "rd_data at reset", int'(rd_data), 0);
  endtask

  task automatic t_fill_and_overflow();  // R2, R3, R5
    for (int i = 0; i < DEPTH - 1; i++) push(8'(8'h10 + i));
    settle();
    check_eq("R2", "full after DEPTH-1 writes", int'(full), 0);
    push(8'(8'h10 + DEPTH - 1));
    check_eq("R2", "full on DEPTH-th write edge", int'(full), 1);
    push(8'hEE);
    push(8'hEF);
    settle();
    check_eq("R3", "full after ignored writes", int'(full), 1);
    check_eq("R3", "model depth", model.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_expect("R3");
    settle();
    check_eq("R3", "empty after draining DEPTH words", int'(empty), 1);
  endtask

  task automatic t_underflow();  // R4, R10
    logic [DW-1:0] last;
    last = rd_data;
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en = 1'b0;
    #1;
    check_eq("R4", "rd_data after reads while empty", int'(rd_data), int'(last));
    check_eq("R4", "empty stays", int'(empty), 1);
    settle();
    check_eq("R10", "rd_data held while idle", int'(rd_data), int'(last));
    push(8'h33);
    settle();
    pop_expect("R4");
  endtask

  task automatic t_empty_latency();  // R7
    settle();
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = 8'h44;
    model.push_back(8'h44);
    @(posedge wr_clk);
    fork begin #1 wr_en = 1'b0; end join_none
    repeat (3) @(posedge rd_clk);
    #1;
    check_eq("R7", "empty by third rd edge", int'(empty), 0);
    pop_expect("R5");
  endtask

  task automatic t_full_latency();  // R8, R5
    logic [DW-1:0] exp;
    settle();
    for (int i = 0; i < DEPTH; i++) push(8'(8'hA0 + i));
    settle();
    check_eq("R2", "full after refill", int'(full), 1);
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(posedge rd_clk);
    fork begin #1 rd_en = 1'b0; end join_none
    repeat (3) @(posedge wr_clk);
    #1;
    check_eq("R8", "full by third wr edge", int'(full), 0);
    exp = model.pop_front();
    check_eq("R5", "first word after refill", int'(rd_data), int'(exp));
    for (int i = 1; i < DEPTH; i++) pop_expect("R5");
    settle();
    check_eq("R8", "empty after drain", int'(empty), 1);
  endtask

  // R9 streaming over many wraps; also drives every Gray wrap step (R6).
  task automatic t_stream(input int n);
    fork
      begin
        int sent = 0, cyc = 0;
        while (sent < n) begin
          @(negedge wr_clk);
          cyc++;
          if (!full && (cyc % 5) != 3) begin
            wr_en = 1'b1; wr_data = 8'(sent * 7 + 3);
            model.push_back(wr_data);
            sent++;
          end else wr_en = 1'b0;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
      end
      begin
        int got = 0, cyc = 0;
        bit pend = 1'b0;
        logic [DW-1:0] exp;
        while (got < n) begin
          @(negedge rd_clk);
          cyc++;
          rd_en = 1'b0;
          if (pend) begin
            exp = model.pop_front();
            check_eq("R9", "stream word", int'(rd_data), int'(exp));
            got++; pend = 1'b0;
          end
          if (got < n && !empty && (cyc % 7) != 2) begin
            rd_en = 1'b1; pend = 1'b1;
          end
        end
        rd_en = 1'b0;
      end
    join
    settle();
    check_eq("R9", "empty after stream", int'(empty), 1);
    check_eq("R9", "model drained", model.size(), 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(posedge rd_clk);
    t_reset();
    @(negedge wr_clk) wr_rst = 1'b0;
    @(negedge rd_clk) rd_rst = 1'b0;
    t_reset();
    t_fill_and_overflow();
    t_underflow();
    t_empty_latency();
    t_full_latency();
    t_stream(10 * DEPTH);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule